// File: doc/BRIEF.md
# Banked UART Register Access Decoder

This block is the host-facing register file of an enhanced UART. The host sees eight byte-wide locations, selected by a 3-bit offset, with separate read and write strobes. More registers sit behind those locations than there are offsets. The block works out which physical register an access reaches. It bases that choice on the stored line-control value, a hidden flag for the flow-control bank, and two bits of an additional control register.

The block holds the configuration registers and drives their values to the UART core. The configuration registers are interrupt enable, line control, modem control, scratch, the 16-bit baud divisor, the flow-control feature byte, the XON and XOFF characters, and a small indexed file whose entry 0 is the additional control register. Status bytes come from the core as inputs and are returned on reads. Three accesses have side effects in the core: popping the receive holding register, pushing the transmit holding register, and writing FIFO control. Each of these produces a registered one-cycle pulse.

Host reads are combinational. The read data reflects the register state before any write made in the same cycle.

Top module: `uart_bank_decoder`

## Requirements
- R1: With line-control bit 7 clear and the flow-control bank closed, the offsets map as follows. 0 is receive (read) or transmit (write) holding, 1 is interrupt enable, 2 is interrupt status (read) or FIFO control (write), 3 is line control, 4 is modem control, 5 is line status, 6 is modem status and 7 is scratch.
- R2: Line status, modem status, interrupt status and receive holding cannot be written. A write at offset 6 is ignored. A read at offset 2 returns interrupt status, never the stored FIFO control byte.
- R3: With line-control bit 7 set, offsets 0 and 1 read and write the divisor low and high bytes. The divisor changes only through such writes.
- R4: Writing 0xBF to line control opens the flow-control bank. It sets stored bit 7 and keeps stored bits [6:0], so the exported data format is unchanged.
- R5: While the flow-control bank is open, the offsets map as follows. 0 and 1 are the divisor, 2 is the feature byte, 3 is line control, 4 is XON and 6 is XOFF. A line-control write of any value other than 0xBF closes the bank and stores the value in full.
- R6: With additional-control bit 7 set, a read at offset 7 returns the core's receive fill level. Writes at offset 7 still store the scratch byte.
- R7: The scratch byte is the index of the indexed file. A write at offset 5 in the standard bank writes the indexed entry. A read at offset 5 returns that entry when additional-control bit 6 is set, and returns line status otherwise. Entry 0 is the additional control register. An index of NUM_IDX or more reads 0x00 and ignores writes.
- R8: A read of receive holding pulses rx_pop_o. A write of transmit holding pulses tx_push_o, with the byte on tx_data_o. A write of FIFO control outside the flow-control bank pulses fcr_wr_o, with the byte on fcr_o. Each pulse is high for the one cycle after the access, and no other access raises one.
- R9: Synchronous reset clears every stored register, the bank flag and all pulses to zero.
- R10: Reads that reach no register return 0x00. In the flow-control bank these are offsets 5 and 7.
- R11: When both strobes are active in one cycle, the read returns the pre-write state and the effects of both the read and the write take place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| rx_data_i | input | 8 | Receive holding byte from the core |
| isr_i | input | 8 | Interrupt status from the core |
| lsr_i | input | 8 | Line status from the core |
| msr_i | input | 8 | Modem status from the core |
| rx_level_i | input | 8 | Receive fill level from the core |
| tx_data_o | output | 8 | Last transmit byte written |
| tx_push_o | output | 1 | Transmit push pulse |
| rx_pop_o | output | 1 | Receive pop pulse |
| fcr_o | output | 8 | Last FIFO control byte written |
| fcr_wr_o | output | 1 | FIFO control write pulse |
| lcr_o | output | 8 | Stored line control |
| dl_o | output | 16 | Baud divisor |
| ier_o | output | 8 | Interrupt enable |
| mcr_o | output | 8 | Modem control |
| acr_o | output | 8 | Additional control (index 0) |
| efr_o | output | 8 | Flow-control feature byte |
| xon_o | output | 8 | XON character |
| xoff_o | output | 8 | XOFF character |
| idx_regs_o | output | NUM_IDX*8 | All indexed entries, entry 0 in the low byte |

## Verification
Several functions can fall in the same cycle, because a read and a write can share one offset. The pairs that matter are a receive pop with a transmit push at offset 0, and a line-control read with the bank-opening 0xBF write. The bench provokes these with directed accesses that raise both strobes. It also has random traffic raise both strobes at random offsets. Each time, it judges that the returned byte matches its model's state before the write, and that both side effects and the register update appear on the following cycle.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;

  localparam int DW = 8;
  localparam logic [DW-1:0] ENH_KEY = 8'hBF;

  typedef enum logic [3:0] {
    TG_NONE, TG_HOLD, TG_IER, TG_ISFC, TG_LCR, TG_MCR, TG_LSR, TG_MSR,
    TG_SPR, TG_DLL, TG_DLM, TG_EFR, TG_XON, TG_XOFF, TG_IDX, TG_RFL
  } tgt_e;

  // Picks the physical register an access reaches.
  function automatic tgt_e map_target(input logic [2:0] a, input logic dlab,
                                      input logic enh, input logic idx_rd,
                                      input logic ext_rd, input logic is_wr);
    tgt_e t;
    t = TG_NONE;
    if (enh) begin
      case (a)
        3'd0: t = TG_DLL;
        3'd1: t = TG_DLM;
        3'd2: t = TG_EFR;
        3'd3: t = TG_LCR;
        3'd4: t = TG_XON;
        3'd6: t = TG_XOFF;
        default: t = TG_NONE;
      endcase
    end else if (dlab && a == 3'd0) begin
      t = TG_DLL;
    end else if (dlab && a == 3'd1) begin
      t = TG_DLM;
    end else begin
      case (a)
        3'd0: t = TG_HOLD;
        3'd1: t = TG_IER;
        3'd2: t = TG_ISFC;
        3'd3: t = TG_LCR;
        3'd4: t = TG_MCR;
        3'd5: t = (is_wr || idx_rd) ? TG_IDX : TG_LSR;
        3'd6: t = is_wr ? TG_NONE : TG_MSR;
        default: t = (!is_wr && ext_rd) ? TG_RFL : TG_SPR;
      endcase
    end
    return t;
  endfunction

  // Line-control update: the key keeps the format bits and raises bit 7.
  function automatic logic [DW-1:0] lcr_next(input logic [DW-1:0] cur,
                                             input logic [DW-1:0] d);
    return (d == ENH_KEY) ? {1'b1, cur[DW-2:0]} : d;
  endfunction

endpackage

// File: rtl/uart_bank_sel.sv
module uart_bank_sel
  import uart_bank_pkg::*;
(
  input  logic [2:0] addr,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic       dlab,
  input  logic       enh,
  input  logic       idx_rd,
  input  logic       ext_rd,
  output tgt_e       rd_tgt,
  output tgt_e       wr_tgt
);

  always_comb begin
    rd_tgt = rd_en ? map_target(addr, dlab, enh, idx_rd, ext_rd, 1'b0) : TG_NONE;
    wr_tgt = wr_en ? map_target(addr, dlab, enh, idx_rd, ext_rd, 1'b1) : TG_NONE;
  end

endmodule

// File: rtl/uart_idx_regs.sv
module uart_idx_regs #(
  parameter int NUM_IDX = 4,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [DW-1:0]      sel,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic [DW-1:0]      acr_o,
  output logic [NUM_IDX*DW-1:0] flat_o
);

  localparam int IDX_W = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1;
  localparam logic [DW-1:0] IDX_LIM = DW'(NUM_IDX);

  logic [DW-1:0] regs [NUM_IDX];
  logic          in_range;

  assign in_range = (sel < IDX_LIM);

  for (genvar g = 0; g < NUM_IDX; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= '0;
      else if (wr_en && sel == DW'(g)) regs[g] <= wdata;
    end
    assign flat_o[g*DW +: DW] = regs[g];
  end

  assign rdata = in_range ? regs[sel[IDX_W-1:0]] : '0;
  assign acr_o = regs[0];

  // R7
  acr_write_path_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(regs[0])) |-> $past(wr_en && sel == '0));

endmodule

// File: rtl/uart_bank_decoder.sv
module uart_bank_decoder
  import uart_bank_pkg::*;
#(
  parameter int NUM_IDX = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2:0]             addr,
  input  logic                   rd_en,
  input  logic                   wr_en,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  input  logic [7:0]             rx_data_i,
  input  logic [7:0]             isr_i,
  input  logic [7:0]             lsr_i,
  input  logic [7:0]             msr_i,
  input  logic [7:0]             rx_level_i,
  output logic [7:0]             tx_data_o,
  output logic                   tx_push_o,
  output logic                   rx_pop_o,
  output logic [7:0]             fcr_o,
  output logic                   fcr_wr_o,
  output logic [7:0]             lcr_o,
  output logic [15:0]            dl_o,
  output logic [7:0]             ier_o,
  output logic [7:0]             mcr_o,
  output logic [7:0]             acr_o,
  output logic [7:0]             efr_o,
  output logic [7:0]             xon_o,
  output logic [7:0]             xoff_o,
  output logic [NUM_IDX*8-1:0]   idx_regs_o
);

  localparam int DLW = 2 * DW;

  logic [DW-1:0]  lcr_q, ier_q, mcr_q, spr_q, efr_q, xon_q, xoff_q, fcr_q, tx_q;
  logic [DLW-1:0] dl_q;
  logic           enh_q;
  logic           tx_push_q, rx_pop_q, fcr_wr_q;
  logic [DW-1:0]  idx_rdata;
  logic [DW-1:0]  acr_w;
  tgt_e           rd_tgt, wr_tgt;

  // Named events for checking.
  logic enh_enter_w, enh_leave_w;
  assign enh_enter_w = (wr_tgt == TG_LCR) && (wdata == ENH_KEY);
  assign enh_leave_w = (wr_tgt == TG_LCR) && (wdata != ENH_KEY) && enh_q;

  uart_bank_sel sel_i (
    .addr   (addr),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .dlab   (lcr_q[DW-1]),
    .enh    (enh_q),
    .idx_rd (acr_w[6]),
    .ext_rd (acr_w[7]),
    .rd_tgt (rd_tgt),
    .wr_tgt (wr_tgt)
  );

  uart_idx_regs #(.NUM_IDX(NUM_IDX), .DW(DW)) idx_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_tgt == TG_IDX),
    .sel    (spr_q),
    .wdata  (wdata),
    .rdata  (idx_rdata),
    .acr_o  (acr_w),
    .flat_o (idx_regs_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_q <= '0; enh_q <= 1'b0; ier_q <= '0; mcr_q <= '0; spr_q <= '0;
      efr_q <= '0; xon_q <= '0; xoff_q <= '0; dl_q <= '0;
    end else begin
      case (wr_tgt)
        TG_LCR: begin
          lcr_q <= lcr_next(lcr_q, wdata);
          enh_q <= enh_enter_w;
        end
        TG_IER:  ier_q  <= wdata;
        TG_MCR:  mcr_q  <= wdata;
        TG_SPR:  spr_q  <= wdata;
        TG_EFR:  efr_q  <= wdata;
        TG_XON:  xon_q  <= wdata;
        TG_XOFF: xoff_q <= wdata;
        TG_DLL:  dl_q[DW-1:0]   <= wdata;
        TG_DLM:  dl_q[DLW-1:DW] <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_push_q <= 1'b0; rx_pop_q <= 1'b0; fcr_wr_q <= 1'b0;
      tx_q <= '0; fcr_q <= '0;
    end else begin
      tx_push_q <= (wr_tgt == TG_HOLD);
      fcr_wr_q  <= (wr_tgt == TG_ISFC);
      rx_pop_q  <= (rd_tgt == TG_HOLD);
      if (wr_tgt == TG_HOLD) tx_q  <= wdata;
      if (wr_tgt == TG_ISFC) fcr_q <= wdata;
    end
  end

  always_comb begin
    case (rd_tgt)
      TG_HOLD: rdata = rx_data_i;
      TG_IER:  rdata = ier_q;
      TG_ISFC: rdata = isr_i;
      TG_LCR:  rdata = lcr_q;
      TG_MCR:  rdata = mcr_q;
      TG_LSR:  rdata = lsr_i;
      TG_MSR:  rdata = msr_i;
      TG_SPR:  rdata = spr_q;
      TG_DLL:  rdata = dl_q[DW-1:0];
      TG_DLM:  rdata = dl_q[DLW-1:DW];
      TG_EFR:  rdata = efr_q;
      TG_XON:  rdata = xon_q;
      TG_XOFF: rdata = xoff_q;
      TG_IDX:  rdata = idx_rdata;
      TG_RFL:  rdata = rx_level_i;
      default: rdata = '0;
    endcase
  end

  assign tx_data_o = tx_q;
  assign tx_push_o = tx_push_q;
  assign rx_pop_o  = rx_pop_q;
  assign fcr_o     = fcr_q;
  assign fcr_wr_o  = fcr_wr_q;
  assign lcr_o     = lcr_q;
  assign dl_o      = dl_q;
  assign ier_o     = ier_q;
  assign mcr_o     = mcr_q;
  assign acr_o     = acr_w;
  assign efr_o     = efr_q;
  assign xon_o     = xon_q;
  assign xoff_o    = xoff_q;

  // R8
  tx_push_src_chk: assert property (@(posedge clk) disable iff (rst)
    tx_push_o |-> $past(wr_en && addr == 3'd0 && !lcr_q[DW-1]));

  // R8
  rx_pop_src_chk: assert property (@(posedge clk) disable iff (rst)
    rx_pop_o |-> $past(rd_en && addr == 3'd0 && !lcr_q[DW-1]));

  // R4
  enh_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(enh_q) |-> $past(wr_en && addr == 3'd3 && wdata == ENH_KEY));

  // R4
  fmt_keep_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(enh_q) |-> (lcr_q[DW-2:0] == $past(lcr_q[DW-2:0]) && lcr_q[DW-1]));

  // R5
  enh_dlab_chk: assert property (@(posedge clk) disable iff (rst)
    enh_q |-> lcr_q[DW-1]);

  // R3
  dl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> $stable(dl_q));

endmodule

// File: tb/uart_bank_decoder_tb_top.sv
module uart_bank_decoder_tb_top;

  localparam int NI = 4;
  localparam int K_NONE = 0, K_HOLD = 1, K_IER = 2, K_ISFC = 3, K_LCR = 4,
                 K_MCR = 5, K_LSR = 6, K_MSR = 7, K_SPR = 8, K_DLL = 9,
                 K_DLM = 10, K_EFR = 11, K_XON = 12, K_XOFF = 13, K_IDX = 14,
                 K_RFL = 15;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, rd_en, wr_en, tx_push_o, rx_pop_o, fcr_wr_o;
  logic [2:0] addr;
  logic [7:0] wdata, rdata, rx_data_i, isr_i, lsr_i, msr_i, rx_level_i;
  logic [7:0] tx_data_o, fcr_o, lcr_o, ier_o, mcr_o, acr_o, efr_o, xon_o, xoff_o;
  logic [15:0] dl_o;
  logic [NI*8-1:0] idx_regs_o;

  uart_bank_decoder #(.NUM_IDX(NI)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .rx_data_i(rx_data_i), .isr_i(isr_i),
    .lsr_i(lsr_i), .msr_i(msr_i), .rx_level_i(rx_level_i),
    .tx_data_o(tx_data_o), .tx_push_o(tx_push_o), .rx_pop_o(rx_pop_o),
    .fcr_o(fcr_o), .fcr_wr_o(fcr_wr_o), .lcr_o(lcr_o), .dl_o(dl_o),
    .ier_o(ier_o), .mcr_o(mcr_o), .acr_o(acr_o), .efr_o(efr_o),
    .xon_o(xon_o), .xoff_o(xoff_o), .idx_regs_o(idx_regs_o)
  );

  int n_chk = 0, n_fail = 0;

  // Bench model state
  logic [7:0] m_lcr, m_ier, m_mcr, m_spr, m_efr, m_xon, m_xoff, m_fcr, m_tx;
  logic [15:0] m_dl;
  logic m_enh;
  logic [7:0] m_ix [NI];

  task automatic chk(input string req, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int m_tgt(input logic [2:0] a, input bit wr);
    logic [7:0] acr;
    acr = m_ix[0];
    if (m_enh) begin
      if (a == 0) return K_DLL;
      if (a == 1) return K_DLM;
      if (a == 2) return K_EFR;
      if (a == 3) return K_LCR;
      if (a == 4) return K_XON;
      if (a == 6) return K_XOFF;
      return K_NONE;
    end
    if (m_lcr[7] && a == 0) return K_DLL;
    if (m_lcr[7] && a == 1) return K_DLM;
    case (a)
      0: return K_HOLD;
      1: return K_IER;
      2: return K_ISFC;
      3: return K_LCR;
      4: return K_MCR;
      5: return wr ? K_IDX : (acr[6] ? K_IDX : K_LSR);
      6: return wr ? K_NONE : K_MSR;
      default: return (!wr && acr[7]) ? K_RFL : K_SPR;
    endcase
  endfunction

  function automatic logic [7:0] m_rd(input int t);
    case (t)
      K_HOLD: return rx_data_i;
      K_IER:  return m_ier;
      K_ISFC: return isr_i;
      K_LCR:  return m_lcr;
      K_MCR:  return m_mcr;
      K_LSR:  return lsr_i;
      K_MSR:  return msr_i;
      K_SPR:  return m_spr;
      K_DLL:  return m_dl[7:0];
      K_DLM:  return m_dl[15:8];
      K_EFR:  return m_efr;
      K_XON:  return m_xon;
      K_XOFF: return m_xoff;
      K_IDX:  return (m_spr < NI) ? m_ix[m_spr[1:0]] : 8'h00;
      K_RFL:  return rx_level_i;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_write(input int t, input logic [7:0] d);
    case (t)
      K_LCR: begin
        if (d == 8'hBF) begin m_lcr[7] = 1'b1; m_enh = 1'b1; end
        else begin m_lcr = d; m_enh = 1'b0; end
      end
      K_IER:  m_ier = d;
      K_MCR:  m_mcr = d;
      K_SPR:  m_spr = d;
      K_EFR:  m_efr = d;
      K_XON:  m_xon = d;
      K_XOFF: m_xoff = d;
      K_DLL:  m_dl[7:0] = d;
      K_DLM:  m_dl[15:8] = d;
      K_IDX:  if (m_spr < NI) m_ix[m_spr[1:0]] = d;
      K_HOLD: m_tx = d;
      K_ISFC: m_fcr = d;
      default: ;
    endcase
  endtask

  task automatic m_reset();
    m_lcr = 0; m_ier = 0; m_mcr = 0; m_spr = 0; m_efr = 0; m_xon = 0;
    m_xoff = 0; m_fcr = 0; m_tx = 0; m_dl = 0; m_enh = 0;
    for (int i = 0; i < NI; i++) m_ix[i] = 0;
  endtask

  task automatic chk_state(input string req);
    chk(req, lcr_o, m_lcr);
    chk(req, dl_o, m_dl);
    chk(req, ier_o, m_ier);
    chk(req, mcr_o, m_mcr);
    chk(req, efr_o, m_efr);
    chk(req, xon_o, m_xon);
    chk(req, xoff_o, m_xoff);
    chk("R7", acr_o, m_ix[0]);
    for (int i = 0; i < NI; i++) chk("R7", idx_regs_o[i*8 +: 8], m_ix[i]);
  endtask

  task automatic acc(input bit rd, input bit wr, input logic [2:0] a,
                     input logic [7:0] d, input string req);
    int rt, wt;
    rt = rd ? m_tgt(a, 1'b0) : K_NONE;
    wt = wr ? m_tgt(a, 1'b1) : K_NONE;
    @(negedge clk);
    addr = a; wdata = d; rd_en = rd; wr_en = wr;
    #1;
    if (rd) chk(req, rdata, m_rd(rt));
    @(posedge clk);
    #1;
    rd_en = 0; wr_en = 0;
    m_write(wt, d);
    chk("R8", tx_push_o, (wt == K_HOLD) ? 1 : 0);
    chk("R8", fcr_wr_o, (wt == K_ISFC) ? 1 : 0);
    chk("R8", rx_pop_o, (rt == K_HOLD) ? 1 : 0);
    if (wt == K_HOLD) chk("R8", tx_data_o, m_tx);
    if (wt == K_ISFC) chk("R8", fcr_o, m_fcr);
    chk_state(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; rd_en = 0; wr_en = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    m_reset();
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    rst = 1; rd_en = 0; wr_en = 0; addr = 0; wdata = 0;
    rx_data_i = 8'hA5; isr_i = 8'hC1; lsr_i = 8'h60; msr_i = 8'h3B; rx_level_i = 8'h0E;
    m_reset();
    do_reset();
    #1;
    // R9 reset state
    chk_state("R9");
    chk("R9", tx_push_o, 0); chk("R9", rx_pop_o, 0); chk("R9", fcr_wr_o, 0);
    chk("R9", fcr_o, 0); chk("R9", tx_data_o, 0);

    // R1 standard map
    acc(1, 0, 3'd0, 8'h00, "R1");
    acc(0, 1, 3'd1, 8'h0F, "R1");
    acc(1, 0, 3'd1, 8'h00, "R1");
    acc(0, 1, 3'd4, 8'h13, "R1");
    acc(1, 0, 3'd5, 8'h00, "R1");
    acc(1, 0, 3'd6, 8'h00, "R1");
    acc(0, 1, 3'd7, 8'h2C, "R1");
    acc(1, 0, 3'd7, 8'h00, "R1");
    // R2 read-only / write-only
    acc(0, 1, 3'd6, 8'hEE, "R2");
    acc(1, 0, 3'd6, 8'h00, "R2");
    acc(0, 1, 3'd2, 8'hC7, "R2");
    acc(1, 0, 3'd2, 8'h00, "R2");
    // R3 divisor
    acc(0, 1, 3'd3, 8'h83, "R3");
    acc(0, 1, 3'd0, 8'h34, "R3");
    acc(0, 1, 3'd1, 8'h12, "R3");
    acc(1, 0, 3'd0, 8'h00, "R3");
    acc(1, 0, 3'd1, 8'h00, "R3");
    acc(0, 1, 3'd3, 8'h1B, "R3");
    // R4 enter the flow-control bank, format kept
    acc(0, 1, 3'd3, 8'hBF, "R4");
    chk("R4", lcr_o, 8'h9B);
    // R5 flow-control bank
    acc(0, 1, 3'd2, 8'h55, "R5");
    acc(1, 0, 3'd2, 8'h00, "R5");
    acc(0, 1, 3'd4, 8'h11, "R5");
    acc(0, 1, 3'd6, 8'h13, "R5");
    acc(1, 0, 3'd4, 8'h00, "R5");
    acc(0, 1, 3'd3, 8'hBF, "R5");
    // R10 unmapped reads
    acc(1, 0, 3'd5, 8'h00, "R10");
    acc(1, 0, 3'd7, 8'h00, "R10");
    acc(0, 1, 3'd3, 8'h03, "R5");
    chk("R5", lcr_o, 8'h03);
    // R7 indexed file
    acc(0, 1, 3'd7, 8'h00, "R7");
    acc(0, 1, 3'd5, 8'hC0, "R7");
    chk("R7", acr_o, 8'hC0);
    // R6 extended read
    acc(1, 0, 3'd7, 8'h00, "R6");
    acc(0, 1, 3'd7, 8'h02, "R6");
    acc(0, 1, 3'd5, 8'h5A, "R7");
    acc(1, 0, 3'd5, 8'h00, "R7");
    acc(0, 1, 3'd7, 8'h09, "R7");
    acc(0, 1, 3'd5, 8'h77, "R7");
    acc(1, 0, 3'd5, 8'h00, "R10");
    // R11 same-cycle read and write
    acc(1, 1, 3'd0, 8'h3C, "R11");
    acc(1, 1, 3'd3, 8'hBF, "R11");
    acc(1, 1, 3'd3, 8'h07, "R11");

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] a;
      logic [7:0] d;
      bit rd, wr;
      int unsigned r;
      r = $urandom;
      a = 3'($urandom_range(0, 7));
      d = ($urandom_range(0, 7) == 0) ? 8'hBF : 8'($urandom);
      if (a == 3'd7 && r[4]) d = 8'($urandom_range(0, 5));
      rd = r[0] | r[2];
      wr = r[1] | ~rd;
      if (r[9:6] == 0) begin
        rx_data_i = 8'($urandom); isr_i = 8'($urandom); lsr_i = 8'($urandom);
        msr_i = 8'($urandom); rx_level_i = 8'($urandom);
      end
      acc(rd, wr, a, d, (rd && wr) ? "R11" : "R1");
      if (n == 1500) begin
        do_reset();
        #1;
        chk_state("R9");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule